// File: doc/BRIEF.md
# Link Low-Power Entry Controller

This block decides, without any software involvement, when a serial link transmitter may drop into its low-power standby state. It then runs the request/response exchange with the link partner. While the transmit side stays idle (no client packets and no retransmissions queued), an idle timer counts in 16 ns units. A prescaler derived from the core clock frequency produces those units. When the count reaches a programmable 20-bit threshold, the block checks whether enough flow-control credits have built up. If they have, it blocks new client packets and asks the link layer to send the standby request packet every cycle until the partner answers.

An accepting answer drives the transmitter into electrical idle and raises the low-power indication. A refusing answer cancels the attempt, releases the packet block and restarts idle timing. A threshold of zero, or a cleared enable bit, keeps the link active at all times. If credits are short when the threshold is reached, the block waits for them. A new client request during that wait sends it back to counting from zero. A wake input returns the block from standby to the active state.

Top module: `lp_entry_ctrl`

## Requirements
- R1: After reset, `block_tx`, `req_send`, `elec_idle` and `in_low_power` are all low and the idle count is zero.
- R2: While `lp_enable` is high, `timeout_units` is non-zero, `tx_idle` is high and `client_req` is low, the idle count advances by one unit every TICK_DIV clock cycles, where TICK_DIV = round(CLK_MHZ*16/1000), at least 1. With `credit_ok` high, `req_send` first reads high timeout_units*TICK_DIV+1 cycles after counting starts from zero.
- R3: A cycle with `client_req` high or `tx_idle` low clears the idle count and the prescaler, so timing restarts from zero.
- R4: With `timeout_units` equal to zero, the block never leaves the active state, however long the link stays idle.
- R5: With `lp_enable` low, the block never leaves the active state.
- R6: If `credit_ok` is low when the threshold is reached, the block waits with `block_tx` low. It raises `req_send` one cycle after `credit_ok` rises. A `client_req` pulse or a low `tx_idle` during the wait clears the count and returns the block to counting.
- R7: From the start of entry until the partner answers, `block_tx` and `req_send` are high on every cycle, and `client_req` has no effect.
- R8: `partner_nak` during the request returns the block to active on the next cycle: `block_tx` and `req_send` go low and idle timing restarts from zero.
- R9: `partner_ack` during the request moves the block on the next cycle to standby: `elec_idle`, `in_low_power` and `block_tx` high, `req_send` low.
- R10: `wake` in standby returns the block to active on the next cycle with all outputs low and the idle count at zero.
- R11: If `partner_ack` and `partner_nak` arrive in the same cycle, the acceptance wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lp_enable | input | 1 | Autonomous low-power entry permitted |
| timeout_units | input | 20 | Idle threshold in 16 ns units; zero disables entry |
| tx_idle | input | 1 | No client packets or retransmissions pending |
| client_req | input | 1 | Client asks to transmit a packet |
| credit_ok | input | 1 | Enough flow-control credits accumulated |
| partner_ack | input | 1 | Partner accepted the standby request |
| partner_nak | input | 1 | Partner rejected the standby request |
| wake | input | 1 | Return from standby to active |
| block_tx | output | 1 | Hold off new client packets |
| req_send | output | 1 | Send the standby request packet this cycle |
| elec_idle | output | 1 | Put the transmitter into electrical idle |
| in_low_power | output | 1 | Block is in the standby state |

## Verification
The credit-wait state is the hardest condition to reach from the ports. It needs the threshold to expire while `credit_ok` is low, and then a client request to land inside the wait rather than during counting. The stimulus holds `credit_ok` low well past the threshold and confirms that the block is waiting and not requesting. It then pulses `client_req`, raises credits at once, and measures the full restarted latency. A behavioural model in the bench follows every cycle, so the case where acceptance and rejection arrive together is also checked against the expected priority.

// File: rtl/lp_entry_ctrl.sv
module lp_entry_ctrl #(
  parameter int CLK_MHZ   = 250,
  parameter int TIMEOUT_W = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 lp_enable,
  input  logic [TIMEOUT_W-1:0] timeout_units,
  input  logic                 tx_idle,
  input  logic                 client_req,
  input  logic                 credit_ok,
  input  logic                 partner_ack,
  input  logic                 partner_nak,
  input  logic                 wake,
  output logic                 block_tx,
  output logic                 req_send,
  output logic                 elec_idle,
  output logic                 in_low_power
);
  localparam int RAW_DIV  = (CLK_MHZ * 16 + 500) / 1000;
  localparam int TICK_DIV = (RAW_DIV < 1) ? 1 : RAW_DIV;
  localparam int PW       = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

  typedef enum logic [1:0] {S_ACTIVE, S_WAIT, S_REQ, S_LOWPWR} state_t;

  state_t               state;
  logic [PW-1:0]        pre;
  logic [TIMEOUT_W-1:0] units;

  logic armed, quiet, expired, tick;
  assign armed   = lp_enable && (timeout_units != '0);
  assign quiet   = tx_idle && !client_req;
  assign expired = units >= timeout_units;
  assign tick    = (pre == PW'(TICK_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_ACTIVE;
      pre   <= '0;
      units <= '0;
    end else begin
      case (state)
        S_ACTIVE: begin
          if (!armed || !quiet) begin
            pre   <= '0;
            units <= '0;
          end else if (expired) begin
            pre   <= '0;
            units <= '0;
            state <= credit_ok ? S_REQ : S_WAIT;
          end else if (tick) begin
            pre   <= '0;
            units <= units + 1'b1;
          end else begin
            pre <= pre + 1'b1;
          end
        end
        S_WAIT: begin
          if (!armed || !quiet) state <= S_ACTIVE;
          else if (credit_ok)   state <= S_REQ;
        end
        S_REQ: begin
          if (partner_ack)      state <= S_LOWPWR;
          else if (partner_nak) state <= S_ACTIVE;
        end
        S_LOWPWR: begin
          if (wake) state <= S_ACTIVE;
        end
        default: state <= S_ACTIVE;
      endcase
    end
  end

  assign block_tx     = (state == S_REQ) || (state == S_LOWPWR);
  assign req_send     = (state == S_REQ);
  assign elec_idle    = (state == S_LOWPWR);
  assign in_low_power = (state == S_LOWPWR);

  // R7
  req_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_send && !partner_ack && !partner_nak) |=> (req_send && block_tx));

  // R2
  busy_no_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!block_tx && !tx_idle) |=> !req_send);

  // R4
  zero_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!block_tx && timeout_units == '0) |=> !req_send);

  // R5
  disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!block_tx && !lp_enable) |=> !req_send);

  // R8
  nak_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_send && partner_nak && !partner_ack) |=> (!block_tx && !req_send));

  // R9
  ack_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_send && partner_ack) |=> (in_low_power && elec_idle && block_tx && !req_send));

  // R10
  wake_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_low_power && wake) |=> (!in_low_power && !elec_idle && !block_tx));
endmodule

// File: tb/tb_lp_entry_ctrl.sv
`timescale 1ns/1ps
module tb_lp_entry_ctrl;
  localparam int MHZ = 100;
  localparam int DIV = 2;

  logic clk = 0, rst_n = 0;
  logic lp_enable = 0, tx_idle = 0, client_req = 0, credit_ok = 0;
  logic partner_ack = 0, partner_nak = 0, wake = 0;
  logic [19:0] timeout_units = '0;
  logic block_tx, req_send, elec_idle, in_low_power;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lp_entry_ctrl #(.CLK_MHZ(MHZ), .TIMEOUT_W(20)) dut (
    .clk(clk), .rst_n(rst_n), .lp_enable(lp_enable), .timeout_units(timeout_units),
    .tx_idle(tx_idle), .client_req(client_req), .credit_ok(credit_ok),
    .partner_ack(partner_ack), .partner_nak(partner_nak), .wake(wake),
    .block_tx(block_tx), .req_send(req_send), .elec_idle(elec_idle),
    .in_low_power(in_low_power));

  // Behavioural reference: 0 active, 1 waiting for credits, 2 requesting, 3 standby
  int m_st = 0, m_pre = 0, m_cnt = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_pre = 0; m_cnt = 0;
    end else if (m_st == 0) begin
      if (!lp_enable || timeout_units == 0 || !tx_idle || client_req) begin
        m_pre = 0; m_cnt = 0;
      end else if (m_cnt >= int'(timeout_units)) begin
        m_pre = 0; m_cnt = 0; m_st = credit_ok ? 2 : 1;
      end else begin
        m_pre++;
        if (m_pre == DIV) begin m_pre = 0; m_cnt++; end
      end
    end else if (m_st == 1) begin
      if (!lp_enable || timeout_units == 0 || !tx_idle || client_req) m_st = 0;
      else if (credit_ok) m_st = 2;
    end else if (m_st == 2) begin
      if (partner_ack) m_st = 3;
      else if (partner_nak) m_st = 0;
    end else if (wake) m_st = 0;
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check("R7 block_tx model", int'(block_tx), int'(m_st >= 2));
    check("R2 req_send model", int'(req_send), int'(m_st == 2));
    check("R9 elec_idle model", int'(elec_idle), int'(m_st == 3));
    check("R9 in_low_power model", int'(in_low_power), int'(m_st == 3));
  end

  task automatic report();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #1_900_000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // clear the timer with one busy cycle, then count cycles until req_send
  task automatic latency(string tag, int exp);
    int n = 0;
    tx_idle = 0; @(negedge clk); tx_idle = 1;
    while (!req_send && n < 1000) begin @(negedge clk); n++; end
    check(tag, n, exp);
  endtask

  task automatic pulse_ack(bit a, bit k);
    partner_ack = a; partner_nak = k; @(negedge clk);
    partner_ack = 0; partner_nak = 0;
  endtask

  initial begin
    int seen;
    cycles(3);
    check("R1 block_tx reset", int'(block_tx), 0);
    check("R1 req_send reset", int'(req_send), 0);
    check("R1 low power reset", int'(in_low_power | elec_idle), 0);
    rst_n = 1;
    lp_enable = 1; credit_ok = 1; timeout_units = 5;

    latency("R2 entry latency", 5 * DIV + 1);
    pulse_ack(1, 0);
    check("R9 standby entered", int'(in_low_power && elec_idle && block_tx), 1);
    cycles(4);
    wake = 1; @(negedge clk); wake = 0;
    check("R10 active after wake", int'(block_tx | in_low_power | elec_idle), 0);
    seen = 0;
    for (int i = 0; i < 5 * DIV; i++) begin @(negedge clk); seen |= int'(req_send); end
    check("R10 timer restarted", seen, 0);
    @(negedge clk);
    check("R10 request after full delay", int'(req_send), 1);

    // R7: request held while unanswered, client requests ignored
    client_req = 1; cycles(20); client_req = 0;
    check("R7 request still held", int'(req_send && block_tx), 1);
    pulse_ack(0, 1);
    check("R8 released after reject", int'(block_tx | req_send), 0);
    seen = 0;
    for (int i = 0; i < 5 * DIV; i++) begin @(negedge clk); seen |= int'(req_send); end
    check("R8 timer restarted", seen, 0);
    @(negedge clk);
    check("R8 re-request after full delay", int'(req_send), 1);

    pulse_ack(1, 1);
    check("R11 ack wins", int'(in_low_power), 1);
    wake = 1; @(negedge clk); wake = 0;

    // R3: clear by client request mid-count
    tx_idle = 0; @(negedge clk); tx_idle = 1;
    cycles(8);
    client_req = 1; @(negedge clk); client_req = 0;
    seen = 0;
    while (!req_send && seen < 1000) begin @(negedge clk); seen++; end
    check("R3 client_req clears timer", seen, 5 * DIV + 1);
    pulse_ack(0, 1);
    tx_idle = 0; @(negedge clk); tx_idle = 1;
    cycles(7);
    tx_idle = 0; @(negedge clk); tx_idle = 1;
    seen = 0;
    while (!req_send && seen < 1000) begin @(negedge clk); seen++; end
    check("R3 busy cycle clears timer", seen, 5 * DIV + 1);
    pulse_ack(0, 1);

    // R4: zero threshold
    timeout_units = 0; seen = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); seen |= int'(block_tx | req_send); end
    check("R4 zero timeout never enters", seen, 0);

    // R5: disabled
    timeout_units = 5; lp_enable = 0; seen = 0;
    for (int i = 0; i < 200; i++) begin @(negedge clk); seen |= int'(block_tx | req_send); end
    check("R5 disabled never enters", seen, 0);
    lp_enable = 1;

    // R6: credit wait
    credit_ok = 0;
    tx_idle = 0; @(negedge clk); tx_idle = 1;
    cycles(30);
    check("R6 waiting without block", int'(block_tx | req_send), 0);
    credit_ok = 1; @(negedge clk);
    check("R6 request one cycle after credits", int'(req_send), 1);
    pulse_ack(0, 1);
    credit_ok = 0;
    cycles(30);
    client_req = 1; @(negedge clk); client_req = 0; credit_ok = 1;
    seen = 0;
    while (!req_send && seen < 1000) begin @(negedge clk); seen++; end
    check("R6 client_req in wait restarts count", seen, 5 * DIV + 1);
    pulse_ack(0, 1);

    // R2 with a larger threshold
    timeout_units = 37;
    latency("R2 larger threshold latency", 37 * DIV + 1);
    pulse_ack(0, 1);
    cycles(3);
    report();
  end
endmodule